// File: doc/BRIEF.md
# Crossed Row/Column Parity Encoder and Corrector

This block guards a square block of N×N data bits with 2N check bits: one even-parity bit for every row and one for every column. Data bit (r,c) sits at flat index r*N+c. Check bit r (0..N-1) covers row r. Check bit N+c covers column c. In encode mode the block returns the data together with freshly computed check bits. In check mode it takes data and check bits read back from storage and recomputes both parity vectors. It XORs them with the stored bits to form a row syndrome and a column syndrome, then classifies the outcome.

A single flipped data bit shows up as exactly one failing row and exactly one failing column. The block inverts the bit at that crossing and reports its coordinates. A lone failing row or a lone failing column points to a damaged check bit. In that case the data is returned untouched and the check bits are regenerated. Every other non-zero syndrome is reported as uncorrectable, and the inputs are passed through as they came. Requests and results each use a valid/ready handshake. There is one output register, so a result appears in the cycle after its request is accepted. Keeping the block in storage is the caller's job.

Top module: `rc_parity_guard`

## Requirements
- R1: After reset, outValid is 0 and inReady is 1.
- R2: An encode request (inMode=0) returns outData equal to inData. For each r, outCheck[r] is the XOR of row r. For each c, outCheck[N+c] is the XOR of column c. outStatus is 0 (clean) and outRow = outCol = 0.
- R3: A check request (inMode=1) whose data and check bits agree gives outStatus 0, with outData and outCheck equal to the inputs.
- R4: A check request with exactly one failing row r and exactly one failing column c gives outStatus 1 (fixed). outData is the input with bit r*N+c inverted, outCheck equals inCheck, outRow = r and outCol = c. For every other result, outRow and outCol are 0.
- R5: A check request with exactly one failing row and no failing column, or the reverse, gives outStatus 1. outData equals inData, and outCheck holds the row and column parities of the data.
- R6: Any other non-zero syndrome gives outStatus 2 (fatal), with outData and outCheck equal to the inputs. Status code 3 never appears.
- R7: A request accepted on a clock edge (inValid and inReady high) makes outValid high with its result from that edge on.
- R8: While outValid is 1 and outReady is 0, inReady is 0 and all result outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Request can be taken this cycle |
| inMode | input | 1 | 0 = encode, 1 = check |
| inData | input | N*N | Data block, bit r*N+c is row r column c |
| inCheck | input | 2N | Stored check bits (check mode only) |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Consumer takes result |
| outData | output | N*N | Passed or corrected data |
| outCheck | output | 2N | Check bits for the returned data |
| outStatus | output | 2 | 0 clean, 1 fixed, 2 fatal |
| outRow | output | RW | Row of the corrected data bit |
| outCol | output | RW | Column of the corrected data bit |

## Verification
Every result is due exactly one clock edge after its request is accepted. It stays put for as long as outReady is held low. The bench drives requests shortly after a rising edge and samples outputs on falling edges. When a request is accepted, its expected result goes into a queue. Each falling edge that sees outValid and outReady together pops one entry and compares it. A dedicated check confirms that outValid is already high on the first falling edge after acceptance. During backpressure the bench checks, over several falling edges, that inReady stays low and the held result does not change.

// File: rtl/rc_parity_pkg.sv
package rc_parity_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_FIXED = 2'd1,
    ST_FATAL = 2'd2
  } rcStatus_t;

  typedef struct packed {
    logic load;    // capture a new result this cycle
    logic encode;  // captured request is an encode
  } rcStrobe_t;

endpackage

// File: rtl/rc_par_gen.sv
module rc_par_gen #(
  parameter int N = 4
) (
  input  logic [N*N-1:0] blk,
  output logic [N-1:0]   rowPar,
  output logic [N-1:0]   colPar
);
  logic [N-1:0][N-1:0] colBits;

  genvar r, c;
  generate
    for (r = 0; r < N; r++) begin : gRow
      assign rowPar[r] = ^blk[r*N +: N];
      for (c = 0; c < N; c++) begin : gTr
        assign colBits[c][r] = blk[r*N+c];
      end
    end
    for (c = 0; c < N; c++) begin : gCol
      assign colPar[c] = ^colBits[c];
    end
  endgenerate
endmodule

// File: rtl/rc_ctrl.sv
module rc_ctrl
  import rc_parity_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inMode,
  input  logic      outReady,
  output logic      inReady,
  output logic      outValid,
  output rcStrobe_t strobe
);
  logic accept;

  assign inReady = !outValid || outReady;
  assign accept  = inValid && inReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
    end else if (accept) begin
      outValid <= 1'b1;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  always_comb begin
    strobe.load   = accept;
    strobe.encode = !inMode;
  end
endmodule

// File: rtl/rc_datapath.sv
module rc_datapath
  import rc_parity_pkg::*;
#(
  parameter int N  = 4,
  parameter int RW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  rcStrobe_t       strobe,
  input  logic [N*N-1:0]  inData,
  input  logic [2*N-1:0]  inCheck,
  output logic [N*N-1:0]  outData,
  output logic [2*N-1:0]  outCheck,
  output logic [1:0]      outStatus,
  output logic [RW-1:0]   outRow,
  output logic [RW-1:0]   outCol
);
  logic [N-1:0]   rowPar, colPar, synRow, synCol;
  logic [RW-1:0]  hitRow, hitCol;
  logic           rowOne, colOne, rowNone, colNone;
  logic [N*N-1:0] nextData;
  logic [2*N-1:0] nextCheck;
  rcStatus_t      nextStatus;
  logic [RW-1:0]  nextRow, nextCol;

  rc_par_gen #(.N(N)) parI (
    .blk   (inData),
    .rowPar(rowPar),
    .colPar(colPar)
  );

  assign synRow  = rowPar ^ inCheck[N-1:0];
  assign synCol  = colPar ^ inCheck[2*N-1:N];
  assign rowNone = (synRow == '0);
  assign colNone = (synCol == '0);

  function automatic logic isSingle(input logic [N-1:0] v);
    int cnt;
    cnt = 0;
    for (int i = 0; i < N; i++) cnt += int'(v[i]);
    return cnt == 1;
  endfunction

  function automatic logic [RW-1:0] findIdx(input logic [N-1:0] v);
    logic [RW-1:0] idx;
    idx = '0;
    for (int i = 0; i < N; i++) if (v[i]) idx = RW'(i);
    return idx;
  endfunction

  assign rowOne = isSingle(synRow);
  assign colOne = isSingle(synCol);
  assign hitRow = findIdx(synRow);
  assign hitCol = findIdx(synCol);

  always_comb begin
    nextData   = inData;
    nextCheck  = inCheck;
    nextStatus = ST_CLEAN;
    nextRow    = '0;
    nextCol    = '0;
    if (strobe.encode) begin
      nextCheck = {colPar, rowPar};
    end else if (rowNone && colNone) begin
      nextStatus = ST_CLEAN;
    end else if (rowOne && colOne) begin
      nextStatus = ST_FIXED;
      nextData[int'(hitRow)*N + int'(hitCol)] = !inData[int'(hitRow)*N + int'(hitCol)];
      nextRow    = hitRow;
      nextCol    = hitCol;
    end else if ((rowOne && colNone) || (rowNone && colOne)) begin
      nextStatus = ST_FIXED;
      nextCheck  = {colPar, rowPar};
    end else begin
      nextStatus = ST_FATAL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData   <= '0;
      outCheck  <= '0;
      outStatus <= ST_CLEAN;
      outRow    <= '0;
      outCol    <= '0;
    end else if (strobe.load) begin
      outData   <= nextData;
      outCheck  <= nextCheck;
      outStatus <= nextStatus;
      outRow    <= nextRow;
      outCol    <= nextCol;
    end
  end
endmodule

// File: rtl/rc_parity_guard.sv
module rc_parity_guard
  import rc_parity_pkg::*;
#(
  parameter int N  = 4,
  parameter int RW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  output logic           inReady,
  input  logic           inMode,
  input  logic [N*N-1:0] inData,
  input  logic [2*N-1:0] inCheck,
  output logic           outValid,
  input  logic           outReady,
  output logic [N*N-1:0] outData,
  output logic [2*N-1:0] outCheck,
  output logic [1:0]     outStatus,
  output logic [RW-1:0]  outRow,
  output logic [RW-1:0]  outCol
);
  rcStrobe_t strobe;

  rc_ctrl ctrlI (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inMode  (inMode),
    .outReady(outReady),
    .inReady (inReady),
    .outValid(outValid),
    .strobe  (strobe)
  );

  rc_datapath #(.N(N), .RW(RW)) dpI (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inData   (inData),
    .inCheck  (inCheck),
    .outData  (outData),
    .outCheck (outCheck),
    .outStatus(outStatus),
    .outRow   (outRow),
    .outCol   (outCol)
  );
endmodule

// File: rtl/rc_parity_guard_chk.sv
module rc_parity_guard_chk #(
  parameter int N  = 4,
  parameter int RW = (N > 1) ? $clog2(N) : 1
) (
  input logic           clk,
  input logic           rstN,
  input logic           inValid,
  input logic           inReady,
  input logic           inMode,
  input logic [N*N-1:0] inData,
  input logic [2*N-1:0] inCheck,
  input logic           outValid,
  input logic           outReady,
  input logic [N*N-1:0] outData,
  input logic [2*N-1:0] outCheck,
  input logic [1:0]     outStatus,
  input logic [RW-1:0]  outRow,
  input logic [RW-1:0]  outCol
);
  AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid); // R7

  AST_STALL_BLOCKS_IN: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady); // R8

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outCheck)
                                 && $stable(outStatus))); // R8

  AST_NO_CODE3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outStatus != 2'd3)); // R6

  AST_ENCODE_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !inMode) |=> (outStatus == 2'd0 && outData == $past(inData))); // R2

  AST_LOC_ONLY_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outStatus != 2'd1) |-> (outRow == '0 && outCol == '0)); // R4

  AST_FATAL_PASSES: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inMode) |=> (outStatus != 2'd2 || (outData == $past(inData)
                                         && outCheck == $past(inCheck)))); // R6
endmodule

bind rc_parity_guard rc_parity_guard_chk #(.N(N), .RW(RW)) chkI (.*);

// File: tb/tb_rc_parity_guard.sv
module tb_rc_parity_guard;
  localparam int N  = 4;
  localparam int RW = 2;
  localparam int DW = N * N;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inMode = 1'b0, outReady = 1'b1;
  logic [DW-1:0] inData = '0;
  logic [2*N-1:0] inCheck = '0;
  logic inReady, outValid;
  logic [DW-1:0] outData;
  logic [2*N-1:0] outCheck;
  logic [1:0] outStatus;
  logic [RW-1:0] outRow, outCol;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [DW-1:0]  d;
    logic [2*N-1:0] k;
    logic [1:0]     st;
    logic [RW-1:0]  r;
    logic [RW-1:0]  c;
    string          tag;
  } item_t;
  item_t sbq[$];

  always #10 clk = !clk;  // 50 MHz

  rc_parity_guard #(.N(N)) dut (.*);

  function automatic logic [2*N-1:0] par(input logic [DW-1:0] d);
    logic [2*N-1:0] k;
    k = '0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        k[r]   = k[r] ^ d[r*N+c];
        k[N+c] = k[N+c] ^ d[r*N+c];
      end
    return k;
  endfunction

  task automatic check1(input string req, input logic ok, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s", req, msg);
    end
  endtask

  // Monitor: pops one expected result per completed output transfer
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      item_t e;
      total++;
      if (sbq.size() == 0) begin
        bad++;
        $display("FAIL R7 unexpected result actual d=%h expected none", outData);
      end else begin
        e = sbq.pop_front();
        if (outData !== e.d || outCheck !== e.k || outStatus !== e.st ||
            outRow !== e.r || outCol !== e.c) begin
          bad++;
          $display("FAIL %s actual d=%h k=%h st=%0d r=%0d c=%0d expected d=%h k=%h st=%0d r=%0d c=%0d",
                   e.tag, outData, outCheck, outStatus, outRow, outCol,
                   e.d, e.k, e.st, e.r, e.c);
        end
      end
    end
  end

  // Driver: drives after a rising edge, waits for acceptance
  task automatic send(input logic mode, input logic [DW-1:0] d, input logic [2*N-1:0] k,
                      input item_t e);
    inValid = 1'b1; inMode = mode; inData = d; inCheck = k;
    forever begin
      @(negedge clk);
      if (inReady) break;
    end
    sbq.push_back(e);
    @(posedge clk); #4;
    inValid = 1'b0;
  endtask

  function automatic item_t mk(input logic [DW-1:0] d, input logic [2*N-1:0] k,
                               input logic [1:0] st, input int r, input int c, input string tag);
    item_t e;
    e.d = d; e.k = k; e.st = st; e.r = RW'(r); e.c = RW'(c); e.tag = tag;
    return e;
  endfunction

  task automatic dataErr(input logic [DW-1:0] d, input int r, input int c);
    logic [DW-1:0] bad1;
    bad1 = d;
    bad1[r*N+c] = !bad1[r*N+c];
    send(1'b1, bad1, par(d), mk(d, par(d), 2'd1, r, c, "R4"));
  endtask

  initial begin
    logic [DW-1:0] d;
    logic [DW-1:0] held;
    repeat (3) @(posedge clk);
    #4;
    check1("R1", outValid === 1'b0 && inReady === 1'b1, $sformatf(
           "reset actual v=%b rdy=%b expected v=0 rdy=1", outValid, inReady));
    rstN = 1'b1;
    @(posedge clk); #4;

    // R2 encode patterns
    send(1'b0, 16'h0000, '1, mk(16'h0000, par(16'h0000), 2'd0, 0, 0, "R2"));
    send(1'b0, 16'hFFFF, '0, mk(16'hFFFF, par(16'hFFFF), 2'd0, 0, 0, "R2"));
    send(1'b0, 16'hA5C3, '0, mk(16'hA5C3, par(16'hA5C3), 2'd0, 0, 0, "R2"));
    send(1'b0, 16'h0001, '0, mk(16'h0001, 8'h11, 2'd0, 0, 0, "R2"));

    // R3 clean checks
    send(1'b1, 16'h3C96, par(16'h3C96), mk(16'h3C96, par(16'h3C96), 2'd0, 0, 0, "R3"));
    send(1'b1, 16'h0000, 8'h00, mk(16'h0000, 8'h00, 2'd0, 0, 0, "R3"));

    // R4 single data-bit errors
    dataErr(16'h3C96, 0, 0);
    dataErr(16'h3C96, 3, 3);
    dataErr(16'hA5C3, 1, 2);

    // R5 single check-bit errors (row bit 2, column bit 1 at index N+1)
    d = 16'h7E18;
    send(1'b1, d, par(d) ^ 8'h04, mk(d, par(d), 2'd1, 0, 0, "R5"));
    send(1'b1, d, par(d) ^ 8'h20, mk(d, par(d), 2'd1, 0, 0, "R5"));

    // R6 uncorrectable patterns
    d = 16'h3C96;
    send(1'b1, d ^ 16'h0003, par(d), mk(d ^ 16'h0003, par(d), 2'd2, 0, 0, "R6"));
    send(1'b1, d ^ 16'h0021, par(d), mk(d ^ 16'h0021, par(d), 2'd2, 0, 0, "R6"));
    send(1'b1, d ^ 16'h0001, par(d) ^ 8'h02, mk(d ^ 16'h0001, par(d) ^ 8'h02, 2'd2, 0, 0, "R6"));

    // R7 latency: result visible on the first falling edge after acceptance
    inValid = 1'b1; inMode = 1'b0; inData = 16'h1234; inCheck = '0;
    @(negedge clk);
    sbq.push_back(mk(16'h1234, par(16'h1234), 2'd0, 0, 0, "R7"));
    @(posedge clk); #4; inValid = 1'b0;
    @(negedge clk);
    check1("R7", outValid === 1'b1 && outData === 16'h1234, $sformatf(
           "latency actual v=%b d=%h expected v=1 d=1234", outValid, outData));

    // R8 backpressure
    @(posedge clk); #4;
    outReady = 1'b0;
    inValid = 1'b1; inMode = 1'b0; inData = 16'hBEEF; inCheck = '0;
    @(negedge clk);
    sbq.push_back(mk(16'hBEEF, par(16'hBEEF), 2'd0, 0, 0, "R8"));
    @(posedge clk); #4;
    inData = 16'h5555;
    @(negedge clk);
    held = outData;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check1("R8", outValid === 1'b1 && inReady === 1'b0 && outData === held, $sformatf(
             "stall actual v=%b rdy=%b d=%h expected v=1 rdy=0 d=%h",
             outValid, inReady, outData, held));
    end
    @(posedge clk); #4;
    inValid = 1'b0;
    outReady = 1'b1;
    @(negedge clk);
    @(posedge clk); #4;
    repeat (3) @(posedge clk);
    check1("R7", sbq.size() == 0, $sformatf("queue actual=%0d expected 0", sbq.size()));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule